// File: doc/BRIEF.md
# Protected Address Translation Cache

This block is a small fully associative cache of page table entries that sits in the address path of a processor. Each slot remembers one virtual page number, the physical page number it maps to, and three access rights: may-read, may-write and supervisor-only. A lookup presents a virtual address, the access direction and the current privilege level. The block answers in the same cycle with one of three outcomes:

- a physical address, built from the cached physical page number and the untouched page offset;
- a miss, which tells the page walker to go and fetch the entry;
- a fault, raised when the entry is present but the access breaks its rights.

The walker installs what it fetched through a one-cycle refill port. A refill of a page that is not yet cached takes slots in rotation. A refill of a page that is already cached rewrites that slot in place. A flush input drops every entry at once, for example on an address-space switch.

Top module: `xlate_guard_tlb`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss.
- R2: When a valid slot's page number equals the upper bits of `vaddr` and the rights allow the access, `paddrValid` is high and `paddr` equals the stored physical page number followed by `vaddr[PAGE_BITS-1:0]`. `missOut` and `faultOut` are low.
- R3: When no valid slot matches, `missOut` is high, `paddrValid` and `faultOut` are low, and `paddr` is zero.
- R4: A matching lookup with `isWrite`=1 on a slot stored with `fillWr`=0 raises `faultOut`, keeps `paddrValid` low and drives `paddr` to zero.
- R5: A matching lookup with `isWrite`=0 on a slot stored with `fillRd`=0 raises `faultOut`.
- R6: A matching lookup with `userMode`=1 on a slot stored with `fillSup`=1 raises `faultOut`. The same slot accessed with `userMode`=0 translates normally.
- R7: While `lookupEn` is low, `paddrValid`, `missOut` and `faultOut` are all low and `paddr` is zero.
- R8: A refill (`fillEn` high at a clock edge, no flush) can be looked up from the next cycle on.
- R9: A refill of a page number that is not cached writes the slot under a rotating victim pointer and then advances the pointer. After ENTRIES+1 distinct refills, the first of them has been evicted and the other ENTRIES remain cached.
- R10: A refill of a page number that is already cached overwrites that slot in place. The victim pointer does not move and no other slot is disturbed.
- R11: A flush empties every slot at the next clock edge. A lookup in the flush cycle reports a miss. A refill in the flush cycle is dropped.
- R12: During a lookup exactly one of `paddrValid`, `missOut` and `faultOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupEn | input | 1 | A lookup is presented this cycle |
| vaddr | input | VA_W | Virtual address to translate |
| isWrite | input | 1 | 1 = write access, 0 = read access |
| userMode | input | 1 | 1 = user privilege, 0 = supervisor |
| paddr | output | PA_W | Translated physical address, zero unless valid |
| paddrValid | output | 1 | Translation returned |
| missOut | output | 1 | No cached entry; invoke the walker |
| faultOut | output | 1 | Rights violation trap |
| fillEn | input | 1 | Install an entry at this clock edge |
| fillVpn | input | VA_W-PAGE_BITS | Virtual page number of the new entry |
| fillPpn | input | PA_W-PAGE_BITS | Physical page number of the new entry |
| fillRd | input | 1 | Entry allows reads |
| fillWr | input | 1 | Entry allows writes |
| fillSup | input | 1 | Entry is supervisor-only |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench uses the default parameters: 8 slots, a 32-bit virtual address, 4 KiB pages and an 18-bit physical page number. With 8 slots, a sweep of nine distinct refills runs the victim pointer around its full cycle and past the wrap. This makes eviction of the oldest slot observable at the lookup port. The top and bottom page numbers and offsets (all ones in the physical page number and in the offset) show that no bits are lost when the address is assembled.

// File: rtl/xgt_pkg.sv
package xgt_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic sup;
  } rights_t;

  typedef struct packed {
    logic fillEn;
    logic flushAll;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/xgt_entry_array.sv
module xgt_entry_array
  import xgt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  rights_t          fillRights,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             lookHit,
  output logic [PPN_W-1:0] lookPpn,
  output rights_t          lookRights,
  output logic             fillMatch,
  output logic [IDX_W-1:0] fillMatchIdx
);
  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnMem    [ENTRIES];
  logic [PPN_W-1:0]   ppnMem    [ENTRIES];
  rights_t            rightsMem [ENTRIES];
  logic [ENTRIES-1:0] lookVec;
  logic [ENTRIES-1:0] fillVec;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (strobes.flushAll) validQ <= '0;
    else if (strobes.fillEn) validQ[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.fillEn) begin
      vpnMem[wrIdx]    <= fillVpn;
      ppnMem[wrIdx]    <= fillPpn;
      rightsMem[wrIdx] <= fillRights;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookVec[g] = validQ[g] && (vpnMem[g] == lookVpn);
    assign fillVec[g] = validQ[g] && (vpnMem[g] == fillVpn);
  end

  // Slots never share a page number, so at most one match: OR-mux is safe.
  always_comb begin
    lookPpn      = '0;
    lookRights   = '0;
    fillMatchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookVec[i]) begin
        lookPpn    = lookPpn | ppnMem[i];
        lookRights = lookRights | rightsMem[i];
      end
      if (fillVec[i]) fillMatchIdx = IDX_W'(i);
    end
  end

  assign lookHit   = |lookVec;
  assign fillMatch = |fillVec;
endmodule

// File: rtl/xgt_ctrl.sv
module xgt_ctrl
  import xgt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillEn,
  input  logic             flush,
  input  logic             fillMatch,
  input  logic [IDX_W-1:0] fillMatchIdx,
  input  logic             lookupEn,
  input  logic             isWrite,
  input  logic             userMode,
  input  logic             lookHit,
  input  rights_t          lookRights,
  output strobe_t          strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic             paddrValid,
  output logic             missOut,
  output logic             faultOut
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victimQ;
  logic             hitNow;
  logic             badAccess;

  always_comb begin
    strobes.flushAll = flush;
    strobes.fillEn   = fillEn && !flush;
    strobes.advance  = fillEn && !flush && !fillMatch;
  end

  assign wrIdx = fillMatch ? fillMatchIdx : victimQ;

  always_ff @(posedge clk) begin
    if (!rstN) victimQ <= '0;
    else if (strobes.advance) victimQ <= (victimQ == LAST) ? '0 : victimQ + 1'b1;
  end

  assign hitNow    = lookupEn && !flush && lookHit;
  assign badAccess = (isWrite ? !lookRights.wr : !lookRights.rd) ||
                     (userMode && lookRights.sup);

  assign paddrValid = hitNow && !badAccess;
  assign faultOut   = hitNow && badAccess;
  assign missOut    = lookupEn && !hitNow;
endmodule

// File: rtl/xlate_guard_tlb.sv
module xlate_guard_tlb
  import xgt_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 30
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lookupEn,
  input  logic [VA_W-1:0]           vaddr,
  input  logic                      isWrite,
  input  logic                      userMode,
  output logic [PA_W-1:0]           paddr,
  output logic                      paddrValid,
  output logic                      missOut,
  output logic                      faultOut,
  input  logic                      fillEn,
  input  logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] fillPpn,
  input  logic                      fillRd,
  input  logic                      fillWr,
  input  logic                      fillSup,
  input  logic                      flush
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  strobe_t          strobes;
  logic [IDX_W-1:0] wrIdx;
  logic             lookHit;
  logic [PPN_W-1:0] lookPpn;
  rights_t          lookRights;
  logic             fillMatch;
  logic [IDX_W-1:0] fillMatchIdx;
  rights_t          fillRights;

  assign fillRights = '{rd: fillRd, wr: fillWr, sup: fillSup};

  xgt_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) array_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillRights(fillRights),
    .lookVpn(vaddr[VA_W-1:PAGE_BITS]), .lookHit(lookHit), .lookPpn(lookPpn),
    .lookRights(lookRights), .fillMatch(fillMatch), .fillMatchIdx(fillMatchIdx)
  );

  xgt_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .flush(flush),
    .fillMatch(fillMatch), .fillMatchIdx(fillMatchIdx),
    .lookupEn(lookupEn), .isWrite(isWrite), .userMode(userMode),
    .lookHit(lookHit), .lookRights(lookRights), .strobes(strobes), .wrIdx(wrIdx),
    .paddrValid(paddrValid), .missOut(missOut), .faultOut(faultOut)
  );

  assign paddr = paddrValid ? {lookPpn, vaddr[PAGE_BITS-1:0]} : '0;
endmodule

// File: rtl/xlate_guard_tlb_chk.sv
module xlate_guard_tlb_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 30
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      lookupEn,
  input logic [VA_W-1:0]           vaddr,
  input logic [PA_W-1:0]           paddr,
  input logic                      paddrValid,
  input logic                      missOut,
  input logic                      faultOut,
  input logic                      fillEn,
  input logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input logic                      flush
);
  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rstN)
    lookupEn |-> $countones({paddrValid, missOut, faultOut}) == 1);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lookupEn |-> (!paddrValid && !missOut && !faultOut && paddr == '0));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    paddrValid |-> paddr[PAGE_BITS-1:0] == vaddr[PAGE_BITS-1:0]);

  assert_flush_same_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flush && lookupEn) |-> (missOut && !paddrValid && !faultOut));

  assert_flush_after_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !fillEn) |=> (!lookupEn || missOut));

  assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush) |=>
      (flush || !(lookupEn && vaddr[VA_W-1:PAGE_BITS] == $past(fillVpn) && missOut)));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (missOut || faultOut) |-> paddr == '0);
endmodule

bind xlate_guard_tlb xlate_guard_tlb_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) chk_i (
  .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .vaddr(vaddr), .paddr(paddr),
  .paddrValid(paddrValid), .missOut(missOut), .faultOut(faultOut),
  .fillEn(fillEn), .fillVpn(fillVpn), .flush(flush)
);

// File: tb/xlate_guard_tlb_tb.sv
module xlate_guard_tlb_tb_top;
  localparam int ENTRIES = 8;
  localparam int VA_W = 32;
  localparam int PB = 12;
  localparam int PA_W = 30;
  localparam int VPN_W = VA_W - PB;
  localparam int PPN_W = PA_W - PB;

  // op: 0 = refill, 1 = lookup. rt = {rd, wr, sup}. ex = {paddrValid, miss, fault}.
  typedef struct packed {
    logic [1:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic [2:0]       rt;
    logic [PB-1:0]    off;
    logic             wr;
    logic             usr;
    logic [2:0]       ex;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 20'h00010, 18'h00AB3, 3'b110, 12'h000, 1'b0, 1'b0, 3'b000},
    '{2'd0, 20'h00020, 18'h00100, 3'b100, 12'h000, 1'b0, 1'b0, 3'b000},
    '{2'd0, 20'hFFFFF, 18'h3FFFF, 3'b111, 12'h000, 1'b0, 1'b0, 3'b000},
    '{2'd0, 20'h00050, 18'h00005, 3'b010, 12'h000, 1'b0, 1'b0, 3'b000},
    '{2'd1, 20'h00010, 18'h00AB3, 3'b000, 12'h123, 1'b0, 1'b1, 3'b100},
    '{2'd1, 20'h00010, 18'h00AB3, 3'b000, 12'h000, 1'b1, 1'b1, 3'b100},
    '{2'd1, 20'h00020, 18'h00100, 3'b000, 12'hABC, 1'b0, 1'b1, 3'b100},
    '{2'd1, 20'h00020, 18'h00000, 3'b000, 12'hABC, 1'b1, 1'b1, 3'b001},
    '{2'd1, 20'hFFFFF, 18'h00000, 3'b000, 12'h001, 1'b0, 1'b1, 3'b001},
    '{2'd1, 20'hFFFFF, 18'h3FFFF, 3'b000, 12'hFFF, 1'b0, 1'b0, 3'b100},
    '{2'd1, 20'hFFFFF, 18'h3FFFF, 3'b000, 12'h7FE, 1'b1, 1'b0, 3'b100},
    '{2'd1, 20'h00050, 18'h00000, 3'b000, 12'h010, 1'b0, 1'b0, 3'b001},
    '{2'd1, 20'h00050, 18'h00005, 3'b000, 12'h010, 1'b1, 1'b0, 3'b100},
    '{2'd1, 20'h00040, 18'h00000, 3'b000, 12'h555, 1'b0, 1'b0, 3'b010},
    '{2'd1, 20'h00011, 18'h00000, 3'b000, 12'h000, 1'b1, 1'b0, 3'b010},
    '{2'd1, 20'h00000, 18'h00000, 3'b000, 12'h000, 1'b0, 1'b0, 3'b010}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupEn = 1'b0, isWrite = 1'b0, userMode = 1'b0;
  logic [VA_W-1:0] vaddr = '0;
  logic [PA_W-1:0] paddr;
  logic paddrValid, missOut, faultOut;
  logic fillEn = 1'b0, fillRd = 1'b0, fillWr = 1'b0, fillSup = 1'b0, flush = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xlate_guard_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_BITS(PB), .PA_W(PA_W)) dut_i (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .vaddr(vaddr), .isWrite(isWrite),
    .userMode(userMode), .paddr(paddr), .paddrValid(paddrValid), .missOut(missOut),
    .faultOut(faultOut), .fillEn(fillEn), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRd(fillRd), .fillWr(fillWr), .fillSup(fillSup), .flush(flush)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [2:0] rt);
    @(negedge clk);
    fillEn = 1'b1; fillVpn = v; fillPpn = p; {fillRd, fillWr, fillSup} = rt;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Presents a lookup after a falling edge; outputs are combinational, sampled 5 ns later.
  task automatic look(input string req, input logic [VPN_W-1:0] v, input logic [PB-1:0] off,
                      input logic w, input logic u, input logic [2:0] ex, input logic [PPN_W-1:0] p);
    @(negedge clk);
    lookupEn = 1'b1; vaddr = {v, off}; isWrite = w; userMode = u;
    #5;
    check(req, {61'd0, paddrValid, missOut, faultOut}, {61'd0, ex});
    check(req, 64'(paddr), ex[2] ? 64'({p, off}) : 64'd0);
    lookupEn = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    look("R1 reset empty", 20'h00010, 12'h000, 1'b0, 1'b0, 3'b010, '0);
    // R7: idle outputs
    @(negedge clk);
    vaddr = 32'h00010123; lookupEn = 1'b0;
    #5;
    check("R7 idle", {60'd0, paddrValid, missOut, faultOut, |paddr}, 64'd0);

    // Table: refills (R8) then lookups (R2 R3 R4 R5 R6 R12)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd0) doFill(VECS[i].vpn, VECS[i].ppn, VECS[i].rt);
      else look("R2/R3/R4/R5/R6/R12 table", VECS[i].vpn, VECS[i].off, VECS[i].wr,
                VECS[i].usr, VECS[i].ex, VECS[i].ppn);
    end

    // R8: refill visible in next cycle
    doFill(20'h00777, 18'h01234, 3'b110);
    look("R8 refill visible", 20'h00777, 12'h00F, 1'b1, 1'b1, 3'b100, 18'h01234);

    // R11: lookup in the flush cycle misses, and afterwards too
    @(negedge clk);
    flush = 1'b1; lookupEn = 1'b1; vaddr = {20'h00010, 12'h000}; isWrite = 1'b0; userMode = 1'b0;
    #5;
    check("R11 same-cycle miss", {61'd0, paddrValid, missOut, faultOut}, 64'b010);
    @(negedge clk);
    flush = 1'b0; lookupEn = 1'b0;
    look("R11 after flush", 20'h00010, 12'h000, 1'b0, 1'b0, 3'b010, '0);
    look("R11 after flush", 20'h00777, 12'h000, 1'b0, 1'b0, 3'b010, '0);

    // R11: refill dropped when flush coincides
    @(negedge clk);
    flush = 1'b1; fillEn = 1'b1; fillVpn = 20'h00888; fillPpn = 18'h00888; {fillRd, fillWr, fillSup} = 3'b110;
    @(negedge clk);
    flush = 1'b0; fillEn = 1'b0;
    look("R11 fill dropped", 20'h00888, 12'h000, 1'b0, 1'b0, 3'b010, '0);

    // R9: ENTRIES+1 distinct refills evict the first one
    for (int k = 0; k <= ENTRIES; k++) doFill(VPN_W'(20'h01000 + k), PPN_W'(18'h00200 + k), 3'b110);
    look("R9 oldest evicted", 20'h01000, 12'h000, 1'b0, 1'b0, 3'b010, '0);
    for (int k = 1; k <= ENTRIES; k++)
      look("R9 survivors", VPN_W'(20'h01000 + k), 12'h044, 1'b0, 1'b1, 3'b100, PPN_W'(18'h00200 + k));

    // R10: refill of resident page rewrites in place, nothing evicted
    doFill(20'h01003, 18'h2AAAA, 3'b100);
    look("R10 in-place update", 20'h01003, 12'h321, 1'b0, 1'b0, 3'b100, 18'h2AAAA);
    look("R10 in-place rights", 20'h01003, 12'h321, 1'b1, 1'b0, 3'b001, '0);
    for (int k = 1; k <= ENTRIES; k++)
      if (k != 3)
        look("R10 no eviction", VPN_W'(20'h01000 + k), 12'h000, 1'b0, 1'b0, 3'b100, PPN_W'(18'h00200 + k));
    // R9: pointer was not moved by R10, so next new page evicts 0x01001
    doFill(20'h02000, 18'h00999, 3'b110);
    look("R9 rotation continues", 20'h01001, 12'h000, 1'b0, 1'b0, 3'b010, '0);
    look("R9 rotation continues", 20'h01002, 12'h000, 1'b0, 1'b0, 3'b100, 18'h00202);
    look("R9 new page", 20'h02000, 12'hFFF, 1'b0, 1'b0, 3'b100, 18'h00999);

    // R1: reset again clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    look("R1 reset clears", 20'h02000, 12'h000, 1'b0, 1'b0, 3'b010, '0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule